// File: doc/BRIEF.md
# Single-Wire Bus Master Sequencer

This block is the master side of a single-wire, open-drain data line held high by an external pull-up resistor. A host gives it one command at a time. It can send a bus reset and then check for a presence response, write one bit, or read one bit. The block turns each command into a sequence of low pulses, released intervals and sampling points. All of them are timed in whole microseconds. A prescaler derives the microsecond from the system clock, and the cycles per microsecond are set by a parameter.

Two timing sets are built in: a regular speed and a faster overdrive speed. An input picks the set, and the block latches that choice when it accepts a command. The block never drives the line high. It only enables a low driver or releases the line. The line input passes through a two-flop synchronizer before any sample is taken. A presence flag and a read-bit register hold the results. Busy and a one-cycle done pulse frame every command.

Top module: `owm_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, done, lineLowEn, presence and readBit are all 0.
- R2: A command is accepted only when cmdValid is high, busy is low and cmdKind is not 2'b11. A cmdValid pulse while busy, or any cmdKind of 2'b11, starts nothing: the line stays released and busy stays low.
- R3: cmdKind 2'b00 is a bus reset. In regular speed, lineLowEn rises in the cycle after acceptance and stays high for exactly 500 µs. The line is then released for 500 µs, and done follows (1000 µs after the low began).
- R4: In overdrive, the bus reset drives low for exactly 60 µs and then releases the line for 60 µs before done.
- R5: After a bus reset, presence becomes 1 exactly when the synchronized line is low at the sampling point. That point is 70 µs after release in regular speed and 8 µs in overdrive. A write or read command leaves presence unchanged.
- R6: cmdKind 2'b01 writes cmdBit. The low pulse lasts 6 µs for a 1 and 60 µs for a 0 in regular speed, and 1 µs or 7 µs in overdrive. A slot runs 70 µs (regular) or 10 µs (overdrive) from its falling edge.
- R7: cmdKind 2'b10 reads a bit. The low pulse lasts 2 µs (regular) or 1 µs (overdrive). readBit takes the synchronized line level at 13 µs (regular) or 2 µs (overdrive) after the falling edge: 0 if a slave still holds the line low, 1 if the line has returned high.
- R8: The overdrive input (1 = overdrive) is sampled only in the cycle a command is accepted. Changing it during the command does not alter that command's timing.
- R9: busy is high from the cycle after acceptance until the cycle in which done pulses. done is high for exactly one cycle, in the first cycle with busy low.
- R10: After each write or read slot the line stays released for a 2 µs recovery time before done. lineLowEn is never high while busy is low, and it rises only at the start of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command request strobe |
| cmdKind | input | 2 | 00 bus reset, 01 write bit, 10 read bit, 11 no operation |
| cmdBit | input | 1 | Bit value for a write command |
| overdrive | input | 1 | 1 selects overdrive timing, 0 regular timing |
| lineIn | input | 1 | Level of the shared data line (asynchronous) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command completion |
| presence | output | 1 | Result of the last bus reset (1 = slave present) |
| readBit | output | 1 | Result of the last read slot |
| lineLowEn | output | 1 | Enables the open-drain low driver |

## Verification
The bench measures every low pulse and every total command length in clock cycles, at both speeds. A timer that is off by one microsecond or takes the wrong timing set shows up directly. A slave model pulls the line low in windows placed on either side of the sampling points. These include a presence pulse that ends before the sampling point and a read hold that ends just before the read sample point. A design that samples too late, forgets the synchronizer delay or inverts the sampled level would report the wrong presence or read bit. Commands injected while busy, no-operation codes, and a speed input flipped straight after acceptance target a master that restarts, drives spurious low pulses or changes speed in the middle of a sequence.

// File: rtl/owm_pkg.sv
package owm_pkg;

  localparam int TW = 16;

  typedef logic [TW-1:0] usVal_t;

  typedef enum logic [1:0] {
    CMD_RESET = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_NONE  = 2'b11
  } cmdKind_t;

  // One timing set, every field in microseconds
  typedef struct packed {
    usVal_t rstLow;
    usVal_t rstRel;
    usVal_t presAt;
    usVal_t w1Low;
    usVal_t w0Low;
    usVal_t rdLow;
    usVal_t rdSample;
    usVal_t slotLen;
    usVal_t recov;
  } timing_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrTime;
    logic driveLow;
    logic samplePres;
    logic sampleBit;
  } strobes_t;

  function automatic int maxInt(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int CYCLES_PER_US = 100,
  parameter int US_W          = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  strobes_t        st,
  input  logic            lineIn,
  output logic            usTick,
  output logic [US_W-1:0] usCount,
  output logic            lineLowEn,
  output logic            presence,
  output logic            readBit
);

  localparam int PW = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYCLES_PER_US - 1);

  logic [PW-1:0] preCnt;
  logic          syncA;
  logic          syncB;

  // Microsecond prescaler, restarted by the control at each phase boundary
  assign usTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || st.clrTime) begin
      preCnt <= '0;
    end else if (usTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || st.clrTime) begin
      usCount <= '0;
    end else if (usTick) begin
      usCount <= usCount + 1'b1;
    end
  end

  // Two-flop synchronizer, idle level high (pull-up)
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presence <= 1'b0;
    end else if (st.samplePres) begin
      presence <= ~syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      readBit <= 1'b0;
    end else if (st.sampleBit) begin
      readBit <= syncB;
    end
  end

  assign lineLowEn = st.driveLow;

endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int      US_W  = 10,
  parameter timing_t STD_T = '0,
  parameter timing_t OD_T  = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmdValid,
  input  logic [1:0]      cmdKind,
  input  logic            cmdBit,
  input  logic            overdrive,
  input  logic            usTick,
  input  logic [US_W-1:0] usCount,
  output strobes_t        st,
  output logic            busy,
  output logic            done
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_LOW,
    S_RST_REL,
    S_SLOT_LOW,
    S_SLOT_REL,
    S_RECOV
  } state_t;

  state_t   state;
  state_t   stateNxt;
  logic     odQ;
  logic     readQ;
  logic     bitQ;
  logic     doneSet;
  timing_t  cur;
  usVal_t   lowUs;
  cmdKind_t kindIn;
  logic     accept;

  assign kindIn = cmdKind_t'(cmdKind);
  assign accept = cmdValid && (state == S_IDLE) && (kindIn != CMD_NONE);
  assign cur    = odQ ? OD_T : STD_T;
  assign lowUs  = readQ ? cur.rdLow : (bitQ ? cur.w1Low : cur.w0Low);

  // True in the cycle that completes n microseconds since the last clear
  function automatic logic elapsed(input usVal_t n);
    return usTick && (usCount == US_W'(n - usVal_t'(1)));
  endfunction

  always_comb begin
    st       = '0;
    stateNxt = state;
    doneSet  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          st.clrTime = 1'b1;
          stateNxt   = (kindIn == CMD_RESET) ? S_RST_LOW : S_SLOT_LOW;
        end
      end
      S_RST_LOW: begin
        st.driveLow = 1'b1;
        if (elapsed(cur.rstLow)) begin
          st.clrTime = 1'b1;
          stateNxt   = S_RST_REL;
        end
      end
      S_RST_REL: begin
        if (elapsed(cur.presAt)) begin
          st.samplePres = 1'b1;
        end
        if (elapsed(cur.rstRel)) begin
          doneSet  = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_SLOT_LOW: begin
        st.driveLow = 1'b1;
        if (elapsed(lowUs)) begin
          stateNxt = S_SLOT_REL;
        end
      end
      S_SLOT_REL: begin
        if (readQ && elapsed(cur.rdSample)) begin
          st.sampleBit = 1'b1;
        end
        if (elapsed(cur.slotLen)) begin
          st.clrTime = 1'b1;
          stateNxt   = S_RECOV;
        end
      end
      S_RECOV: begin
        if (elapsed(cur.recov)) begin
          doneSet  = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneSet;
    end
  end

  // Command attributes, latched only on acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      odQ   <= 1'b0;
      readQ <= 1'b0;
      bitQ  <= 1'b0;
    end else if (accept) begin
      odQ   <= overdrive;
      readQ <= (kindIn == CMD_READ);
      bitQ  <= cmdBit;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/owm_top.sv
module owm_top
  import owm_pkg::*;
#(
  parameter int CYCLES_PER_US  = 100,
  parameter int STD_RST_LOW_US = 500,
  parameter int STD_RST_REL_US = 500,
  parameter int STD_PRES_US    = 70,
  parameter int STD_W1_US      = 6,
  parameter int STD_W0_US      = 60,
  parameter int STD_RD_LOW_US  = 2,
  parameter int STD_RD_SMP_US  = 13,
  parameter int STD_SLOT_US    = 70,
  parameter int STD_REC_US     = 2,
  parameter int OD_RST_LOW_US  = 60,
  parameter int OD_RST_REL_US  = 60,
  parameter int OD_PRES_US     = 8,
  parameter int OD_W1_US       = 1,
  parameter int OD_W0_US       = 7,
  parameter int OD_RD_LOW_US   = 1,
  parameter int OD_RD_SMP_US   = 2,
  parameter int OD_SLOT_US     = 10,
  parameter int OD_REC_US      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  input  logic       cmdBit,
  input  logic       overdrive,
  input  logic       lineIn,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       readBit,
  output logic       lineLowEn
);

  localparam timing_t STD_T = '{
    rstLow:   usVal_t'(STD_RST_LOW_US),
    rstRel:   usVal_t'(STD_RST_REL_US),
    presAt:   usVal_t'(STD_PRES_US),
    w1Low:    usVal_t'(STD_W1_US),
    w0Low:    usVal_t'(STD_W0_US),
    rdLow:    usVal_t'(STD_RD_LOW_US),
    rdSample: usVal_t'(STD_RD_SMP_US),
    slotLen:  usVal_t'(STD_SLOT_US),
    recov:    usVal_t'(STD_REC_US)
  };

  localparam timing_t OD_T = '{
    rstLow:   usVal_t'(OD_RST_LOW_US),
    rstRel:   usVal_t'(OD_RST_REL_US),
    presAt:   usVal_t'(OD_PRES_US),
    w1Low:    usVal_t'(OD_W1_US),
    w0Low:    usVal_t'(OD_W0_US),
    rdLow:    usVal_t'(OD_RD_LOW_US),
    rdSample: usVal_t'(OD_RD_SMP_US),
    slotLen:  usVal_t'(OD_SLOT_US),
    recov:    usVal_t'(OD_REC_US)
  };

  localparam int MAX_STD = maxInt(maxInt(STD_RST_LOW_US, STD_RST_REL_US),
                                  maxInt(STD_SLOT_US, STD_REC_US));
  localparam int MAX_OD  = maxInt(maxInt(OD_RST_LOW_US, OD_RST_REL_US),
                                  maxInt(OD_SLOT_US, OD_REC_US));
  localparam int US_W    = $clog2(maxInt(MAX_STD, MAX_OD) + 1);

  strobes_t        st;
  logic            usTick;
  logic [US_W-1:0] usCount;

  owm_ctrl #(
    .US_W  (US_W),
    .STD_T (STD_T),
    .OD_T  (OD_T)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cmdValid  (cmdValid),
    .cmdKind   (cmdKind),
    .cmdBit    (cmdBit),
    .overdrive (overdrive),
    .usTick    (usTick),
    .usCount   (usCount),
    .st        (st),
    .busy      (busy),
    .done      (done)
  );

  owm_datapath #(
    .CYCLES_PER_US (CYCLES_PER_US),
    .US_W          (US_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .lineIn    (lineIn),
    .usTick    (usTick),
    .usCount   (usCount),
    .lineLowEn (lineLowEn),
    .presence  (presence),
    .readBit   (readBit)
  );

endmodule

// File: rtl/owm_chk.sv
module owm_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmdValid,
  input logic [1:0] cmdKind,
  input logic       busy,
  input logic       done,
  input logic       presence,
  input logic       readBit,
  input logic       lineLowEn
);

  // R9: done only appears with busy low
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: busy falls only together with done
  a_r9_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: no low drive while idle
  a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lineLowEn);

  // R3: an accepted command begins with the line pulled low
  a_r3_starts_low: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !busy && cmdKind != 2'b11) |=> (busy && lineLowEn));

  // R2: the no-operation code starts nothing
  a_r2_nop_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !busy && cmdKind == 2'b11) |=> !busy);

  // R5: presence changes only inside a command
  a_r5_presence_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(presence) |-> busy);

  // R7: readBit changes only inside a command
  a_r7_readbit_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(readBit) |-> busy);

endmodule

bind owm_top owm_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmdValid  (cmdValid),
  .cmdKind   (cmdKind),
  .busy      (busy),
  .done      (done),
  .presence  (presence),
  .readBit   (readBit),
  .lineLowEn (lineLowEn)
);

// File: tb/owm_top_tb_top.sv
module owm_top_tb_top;

  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdKind = 2'b00;
  logic       cmdBit = 1'b0;
  logic       overdrive = 1'b0;
  logic       slaveLow = 1'b0;
  logic       busy, done, presence, readBit, lineLowEn;
  logic       lineIn;

  assign lineIn = !(lineLowEn || slaveLow);

  always #5 clk = ~clk;

  owm_top #(.CYCLES_PER_US(CPU)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .cmdValid  (cmdValid),
    .cmdKind   (cmdKind),
    .cmdBit    (cmdBit),
    .overdrive (overdrive),
    .lineIn    (lineIn),
    .busy      (busy),
    .done      (done),
    .presence  (presence),
    .readBit   (readBit),
    .lineLowEn (lineLowEn)
  );

  int checks = 0;
  int fails  = 0;
  int lowStart, lowEnd, doneAt, busyBad, extraLow, donePost;
  logic lastPres = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Timing values taken from the requirements (microseconds)
  function automatic int tRstLow(input bit od); return od ? 60 : 500; endfunction
  function automatic int tRstRel(input bit od); return od ? 60 : 500; endfunction
  function automatic int tPres(input bit od);   return od ? 8 : 70;   endfunction
  function automatic int tSlot(input bit od);   return od ? 10 : 70;  endfunction
  function automatic int tSample(input bit od); return od ? 2 : 13;   endfunction

  function automatic int expLow(input int kind, input bit b, input bit od);
    if (kind == 0) return tRstLow(od) * CPU;
    if (kind == 1) return (b ? (od ? 1 : 6) : (od ? 7 : 60)) * CPU;
    return (od ? 1 : 2) * CPU;
  endfunction

  function automatic int expTotal(input int kind, input bit od);
    if (kind == 0) return (tRstLow(od) + tRstRel(od)) * CPU;
    return (tSlot(od) + 2) * CPU;
  endfunction

  function automatic logic expPres(input bit od, input int mode, input int st, input int len);
    return (mode == 1) && (st < tPres(od)) && (st + len > tPres(od));
  endfunction

  function automatic logic expBit(input bit od, input int hold);
    return !(hold > tSample(od));
  endfunction

  // Issue one command and measure it; slave mode 1 = presence pulse, 2 = read hold
  task automatic runCmd(input int kind, input bit b, input bit od,
                        input int mode, input int aUs, input int bUs, input int injectAt);
    @(negedge clk);
    cmdValid = 1'b1; cmdKind = 2'(kind); cmdBit = b; overdrive = od;
    @(negedge clk);
    cmdValid = 1'b0;
    overdrive = !od;  // R8: flipped right after acceptance
    lowStart = -1; lowEnd = -1; doneAt = -1; busyBad = 0; extraLow = 0;
    for (int k = 0; k < 20000 && doneAt < 0; k++) begin
      if (lineLowEn && lowStart < 0) lowStart = k;
      else if (lineLowEn && lowEnd >= 0) extraLow++;
      if (!lineLowEn && lowStart >= 0 && lowEnd < 0) lowEnd = k;
      if (done) doneAt = k;
      else if (!busy) busyBad++;
      slaveLow = 1'b0;
      if (mode == 1 && lowEnd >= 0 && k + 1 >= lowEnd + aUs * CPU &&
          k + 1 < lowEnd + (aUs + bUs) * CPU) slaveLow = 1'b1;
      if (mode == 2 && lowStart >= 0 && k + 1 < lowStart + aUs * CPU) slaveLow = 1'b1;
      cmdValid = (k == injectAt);
      @(negedge clk);
    end
    slaveLow = 1'b0;
    cmdValid = 1'b0;
    donePost = done;
  endtask

  task automatic checkCmd(input int kind, input bit b, input bit od,
                          input int mode, input int aUs, input int bUs);
    string rq;
    rq = (kind == 0) ? (od ? "R4" : "R3") : (kind == 1 ? "R6" : "R7");
    check("R9", "done reached", (doneAt >= 0) ? 1 : 0, 1);
    check(rq, "low starts after accept", lowStart, 0);
    check(rq, "low length cycles (R8 speed latched)", lowEnd - lowStart, expLow(kind, b, od));
    check(rq, "command length cycles", doneAt - lowStart, expTotal(kind, od));
    check("R9", "busy gaps", busyBad, 0);
    check("R9", "done width", donePost, 0);
    check("R10", "extra low pulses", extraLow, 0);
    if (kind == 0) begin
      lastPres = expPres(od, mode, aUs, bUs);
      check("R5", "presence", presence, lastPres);
    end else begin
      check("R5", "presence unchanged by slot", presence, lastPres);
    end
    if (kind == 2) check("R7", "read bit", readBit, expBit(od, (mode == 2) ? aUs : 0));
  endtask

  task automatic doCmd(input int kind, input bit b, input bit od,
                       input int mode, input int aUs, input int bUs);
    runCmd(kind, b, od, mode, aUs, bUs, -1);
    checkCmd(kind, b, od, mode, aUs, bUs);
  endtask

  task automatic quietCheck(input int us, input string req);
    int bad;
    bad = 0;
    for (int k = 0; k < us * CPU; k++) begin
      @(negedge clk);
      if (lineLowEn || busy || done) bad++;
    end
    check(req, "quiet cycles with activity", bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "lineLowEn in reset", lineLowEn, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "lineLowEn after reset", lineLowEn, 0);
    check("R1", "presence after reset", presence, 0);
    check("R1", "readBit after reset", readBit, 0);

    // Directed bus resets
    doCmd(0, 0, 0, 1, 30, 120);   // R3 R5 slave answers
    doCmd(0, 0, 0, 0, 0, 0);      // R5 no slave
    doCmd(0, 0, 0, 1, 20, 40);    // R5 pulse over before sampling point
    doCmd(0, 0, 1, 1, 3, 10);     // R4 overdrive presence
    doCmd(0, 0, 1, 0, 0, 0);      // R4 overdrive no slave
    doCmd(0, 0, 1, 1, 2, 24);     // R4 R5 sets presence for slot checks

    // Directed slots
    doCmd(1, 1, 0, 0, 0, 0);      // R6 write one
    doCmd(1, 0, 0, 0, 0, 0);      // R6 write zero
    doCmd(1, 1, 1, 0, 0, 0);
    doCmd(1, 0, 1, 0, 0, 0);
    doCmd(2, 0, 0, 2, 30, 0);     // R7 slave sends 0
    doCmd(2, 0, 0, 0, 0, 0);      // R7 slave sends 1
    doCmd(2, 0, 0, 2, 11, 0);     // R7 hold ends before sampling point
    doCmd(2, 0, 1, 2, 4, 0);      // R7 overdrive 0
    doCmd(2, 0, 1, 0, 0, 0);      // R7 overdrive 1

    // R2: command injected while busy, then no-operation code
    runCmd(1, 1, 0, 0, 0, 0, 20);
    checkCmd(1, 1, 0, 0, 0, 0);
    quietCheck(100, "R2");
    @(negedge clk);
    cmdValid = 1'b1; cmdKind = 2'b11;
    @(negedge clk);
    cmdValid = 1'b0;
    quietCheck(50, "R2");

    // Constrained random mix
    for (int i = 0; i < 40; i++) begin
      int kind, mode, a, l;
      bit od, b;
      od   = 1'($urandom % 2);
      b    = 1'($urandom % 2);
      kind = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 2);
      mode = 0; a = 0; l = 0;
      if (kind == 0 && ($urandom % 4 != 0)) begin
        mode = 1;
        a = od ? 2 + $urandom % 4 : 15 + $urandom % 36;
        l = od ? 7 + $urandom % 14 : 60 + $urandom % 141;
      end else if (kind == 2 && ($urandom % 2 == 1)) begin
        mode = 2;
        a = od ? 3 + $urandom % 4 : 15 + $urandom % 31;
      end
      doCmd(kind, b, od, mode, a, l);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule